// File: doc/BRIEF.md
# Serial EEPROM Command Register Front-End

This block is the register side of a serial EEPROM access path. Software sees one 32-bit command word. The word holds a byte address, a data byte, a read/write selector, and three status flags: busy, done and error. There is no separate start bit. Writing to the data byte while the block is idle launches one single-byte access. For a write access, that byte is the value stored into the EEPROM. For a read access, the byte written is thrown away.

Once an access is launched, the block presents address, data and direction to a back-end bus engine. It holds a request line high until the engine answers with a one-cycle acknowledge. On that acknowledge the block records the engine's error indication and, for reads, captures the returned byte into the data field. It then drops busy and raises done. Software polls busy or done before using read data or issuing the next access.

Top module: `eeprom_fe_top`

## Requirements
- R1: After reset every field and flag of the command word reads as zero and `be_req` is low.
- R2: A register write whose byte strobes cover any of bits 23:16 while busy (bit 24) is 0 launches an access: in the next cycle busy reads 1, done (bit 26) and error (bit 27) read 0, and `be_req` is high.
- R3: When bit 25 is 0 (write), the launched access drives `be_rd` low and `be_wdata` equal to the byte written into bits 23:16.
- R4: When bit 25 is 1 (read), the byte written into bits 23:16 at launch is discarded and the field keeps its prior value while busy; the cycle after the acknowledge, bits 23:16 hold `be_rdata` as sampled with it.
- R5: `be_req` stays high with `be_addr`, `be_wdata` and `be_rd` unchanged until `be_ack` is seen; busy reads 0 and `be_req` is low in the cycle after the acknowledge.
- R6: While busy is 1, register writes change none of the address, data or selector fields and start no further access.
- R7: Done is set the cycle after the acknowledge and cleared by the next launch; busy and done are never both 1.
- R8: The error bit takes the value of `be_err` at the acknowledge, holds through later non-launching writes, and is cleared when the next access launches.
- R9: Writes whose strobes touch only the address bytes (bits 15:0) or only the top byte (selector bit 25) update those fields without launching an access.
- R10: Command word layout: bits 15:0 address, 23:16 data, 24 busy, 25 selector, 26 done, 27 error; bits 31:28 always read 0 and busy cannot be written.
- R11: An acknowledge that arrives while busy is 0 changes no register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_wr_strb | input | 4 | Byte enables for the write, bit n covers bits 8n+7:8n |
| reg_rd_data | output | 32 | Current command word |
| be_req | output | 1 | Access request to the back-end |
| be_addr | output | 16 | EEPROM byte address for the access |
| be_wdata | output | 8 | Byte to store on a write access |
| be_rd | output | 1 | 1 = read access, 0 = write access |
| be_ack | input | 1 | One-cycle completion pulse from the back-end |
| be_rdata | input | 8 | Byte returned by a read, valid with `be_ack` |
| be_err | input | 1 | Access failed, valid with `be_ack` |

## Verification
The assertions take for granted that the back-end pulses `be_ack` for exactly one cycle and only while `be_req` is high, and that `be_rdata` and `be_err` are meaningful only in that cycle. The bench's back-end model keeps to these rules: it answers a request after a programmable delay and releases the acknowledge on the next cycle. An acknowledge outside a request is driven only once, on purpose, to show that the block ignores it. Register writes are timed freely, including during busy, because the block must tolerate any software timing.

// File: rtl/eeprom_fe_pkg.sv
package eeprom_fe_pkg;

  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } fe_state_e;

  // True when any enabled byte lane overlaps bits [lsb +: width].
  function automatic logic span_touched(input logic [15:0] strb,
                                        input int lsb,
                                        input int width);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < 16; b++) begin
      if (strb[b] && (b * 8 + 7 >= lsb) && (b * 8 <= lsb + width - 1))
        hit = 1'b1;
    end
    return hit;
  endfunction

endpackage

// File: rtl/eeprom_fe_decode.sv
module eeprom_fe_decode #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int STRB_W   = REG_W / 8,
  localparam int DATA_LSB = ADDR_W,
  localparam int OP_BIT   = ADDR_W + DATA_W + 1
) (
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  output logic              addr_hit,
  output logic              data_hit,
  output logic              op_hit
);
  import eeprom_fe_pkg::*;

  logic [15:0] strb_ext;

  always_comb begin
    strb_ext = '0;
    strb_ext[STRB_W-1:0] = wr_strb;
  end

  always_comb begin
    addr_hit = wr_en && span_touched(strb_ext, 0, ADDR_W);
    data_hit = wr_en && span_touched(strb_ext, DATA_LSB, DATA_W);
    op_hit   = wr_en && span_touched(strb_ext, OP_BIT, 1);
  end

endmodule

// File: rtl/eeprom_fe_ctrl.sv
module eeprom_fe_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic data_hit,
  input  logic be_ack,
  input  logic be_err,
  output logic launch,
  output logic capture,
  output logic busy,
  output logic done,
  output logic err
);
  import eeprom_fe_pkg::*;

  fe_state_e state;

  assign busy    = (state == ST_WAIT);
  assign launch  = data_hit && (state == ST_IDLE);
  assign capture = be_ack && (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state <= ST_WAIT;
            done  <= 1'b0;
            err   <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (capture) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            err   <= be_err;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_launch_sets_busy: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy && !done && !err);

  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    capture |=> done && !busy);

  a_r7_busy_done_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    !busy && !data_hit |=> err == $past(err));

  a_r11_idle_ack_ignored: assert property (@(posedge clk) disable iff (rst)
    !busy && be_ack && !data_hit |=> $stable(done) && $stable(err) && !busy);

endmodule

// File: rtl/eeprom_fe_fields.sv
module eeprom_fe_fields #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int DATA_LSB = ADDR_W,
  localparam int OP_BIT   = ADDR_W + DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              addr_hit,
  input  logic              op_hit,
  input  logic              busy,
  input  logic              launch,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              op_q
);
  import eeprom_fe_pkg::*;

  logic op_next;

  assign op_next = (op_hit && !busy) ? wr_data[OP_BIT] : op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      op_q   <= OP_WRITE;
    end else if (!busy) begin
      if (addr_hit) addr_q <= wr_data[ADDR_W-1:0];
      if (op_hit)   op_q   <= wr_data[OP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (capture && op_q == OP_READ) begin
      data_q <= rdata;
    end else if (launch && op_next == OP_WRITE) begin
      data_q <= wr_data[DATA_LSB +: DATA_W];
    end
  end

  a_r4_read_capture: assert property (@(posedge clk) disable iff (rst)
    capture && op_q == OP_READ |=> data_q == $past(rdata));

  a_r6_fields_frozen: assert property (@(posedge clk) disable iff (rst)
    busy && !capture |=> $stable(addr_q) && $stable(op_q) && $stable(data_q));

endmodule

// File: rtl/eeprom_fe_top.sv
module eeprom_fe_top #(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int STRB_W   = REG_W / 8,
  localparam int DATA_LSB = ADDR_W,
  localparam int BUSY_BIT = ADDR_W + DATA_W,
  localparam int OP_BIT   = BUSY_BIT + 1,
  localparam int DONE_BIT = BUSY_BIT + 2,
  localparam int ERR_BIT  = BUSY_BIT + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic [STRB_W-1:0] reg_wr_strb,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              be_req,
  output logic [ADDR_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_wdata,
  output logic              be_rd,
  input  logic              be_ack,
  input  logic [DATA_W-1:0] be_rdata,
  input  logic              be_err
);

  logic addr_hit, data_hit, op_hit;
  logic launch, capture, busy, done, err;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic op_q;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{reg_wr_data[REG_W-1:OP_BIT+1], reg_wr_data[BUSY_BIT]};

  eeprom_fe_decode #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .wr_en    (reg_wr_en),
    .wr_strb  (reg_wr_strb),
    .addr_hit (addr_hit),
    .data_hit (data_hit),
    .op_hit   (op_hit)
  );

  eeprom_fe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .data_hit (data_hit),
    .be_ack   (be_ack),
    .be_err   (be_err),
    .launch   (launch),
    .capture  (capture),
    .busy     (busy),
    .done     (done),
    .err      (err)
  );

  eeprom_fe_fields #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fields (
    .clk      (clk),
    .rst      (rst),
    .wr_data  (reg_wr_data),
    .addr_hit (addr_hit),
    .op_hit   (op_hit),
    .busy     (busy),
    .launch   (launch),
    .capture  (capture),
    .rdata    (be_rdata),
    .addr_q   (addr_q),
    .data_q   (data_q),
    .op_q     (op_q)
  );

  always_comb begin
    reg_rd_data = '0;
    reg_rd_data[ADDR_W-1:0]          = addr_q;
    reg_rd_data[DATA_LSB +: DATA_W]  = data_q;
    reg_rd_data[BUSY_BIT]            = busy;
    reg_rd_data[OP_BIT]              = op_q;
    reg_rd_data[DONE_BIT]            = done;
    reg_rd_data[ERR_BIT]             = err;
  end

  assign be_req   = busy;
  assign be_addr  = addr_q;
  assign be_wdata = data_q;
  assign be_rd    = op_q;

  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    be_req && !be_ack |=> be_req && $stable(be_addr) && $stable(be_wdata) && $stable(be_rd));

  a_r5_req_drops: assert property (@(posedge clk) disable iff (rst)
    be_req && be_ack |=> !be_req);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[REG_W-1:ERR_BIT+1] == '0);

endmodule

// File: tb/eeprom_fe_top_tb.sv
`timescale 1ns/1ps
module eeprom_fe_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_wr_strb = '0;
  logic [31:0] reg_rd_data;
  logic        be_req;
  logic [15:0] be_addr;
  logic [7:0]  be_wdata;
  logic        be_rd;
  logic        be_ack;
  logic [7:0]  be_rdata = '0;
  logic        be_err = 1'b0;

  logic model_ack = 1'b0;
  logic idle_ack  = 1'b0;
  assign be_ack = model_ack | idle_ack;

  always #2.5 clk = ~clk;

  eeprom_fe_top u_dut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_wr_strb(reg_wr_strb),
    .reg_rd_data(reg_rd_data),
    .be_req(be_req), .be_addr(be_addr), .be_wdata(be_wdata), .be_rd(be_rd),
    .be_ack(be_ack), .be_rdata(be_rdata), .be_err(be_err)
  );

  typedef struct { logic [15:0] a; logic [7:0] d; logic rd; } req_t;
  req_t exp_q[$];

  int checks = 0;
  int errors = 0;
  int lat = 3;
  logic [7:0] m_rdata = '0;
  logic       m_err = 1'b0;
  bit finished = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Back-end model and scoreboard monitor
  initial begin : monitor
    bit   active = 0;
    int   waited = 0;
    req_t cur;
    forever begin
      @(negedge clk);
      if (model_ack) begin
        model_ack = 1'b0;
        active = 0;
        check("R5", "req low after ack", {31'b0, be_req}, 32'd0);
      end else if (be_req) begin
        if (!active) begin
          active = 1;
          waited = 0;
          if (exp_q.size() == 0) begin
            check("R6", "unexpected request", 32'd1, 32'd0);
            cur = '{a: be_addr, d: be_wdata, rd: be_rd};
          end else begin
            cur = exp_q.pop_front();
          end
        end
        check("R5", "be_addr held", {16'b0, be_addr}, {16'b0, cur.a});
        check("R3", "be_rd", {31'b0, be_rd}, {31'b0, cur.rd});
        if (!cur.rd) check("R3", "be_wdata", {24'b0, be_wdata}, {24'b0, cur.d});
        waited++;
        if (waited >= lat) begin
          be_rdata  = m_rdata;
          be_err    = m_err;
          model_ack = 1'b1;
        end
      end
    end
  end

  task automatic reg_write(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_data = d; reg_wr_strb = s;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_strb = '0;
  endtask

  task automatic launch(input logic [15:0] a, input logic [7:0] d, input logic rd,
                        input logic [3:0] s, input logic [15:0] exp_a);
    exp_q.push_back('{a: exp_a, d: d, rd: rd});
    reg_write({6'b0, rd, 1'b0, d, a}, s);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!reg_rd_data[26] && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(req, "done set", {31'b0, reg_rd_data[26]}, 32'd1);
    check("R5", "busy clear after ack", {31'b0, reg_rd_data[24]}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "reset word", reg_rd_data, 32'd0);
    check("R1", "reset req", {31'b0, be_req}, 32'd0);

    // R11: stray acknowledge while idle
    idle_ack = 1'b1; be_rdata = 8'hEE; be_err = 1'b1;
    @(negedge clk);
    idle_ack = 1'b0; be_err = 1'b0;
    check("R11", "idle ack ignored", reg_rd_data, 32'd0);

    // R9: address-only and selector-only writes
    reg_write(32'hFFFF_1234, 4'b0011);
    check("R9", "addr only", reg_rd_data, 32'h0000_1234);
    check("R9", "no req", {31'b0, be_req}, 32'd0);
    reg_write(32'hFFFF_FFFF, 4'b1000);
    check("R10", "top byte write", reg_rd_data, 32'h0200_1234);

    // R2/R3: write access
    lat = 3;
    launch(16'hA55A, 8'h3C, 1'b0, 4'b1111, 16'hA55A);
    check("R2", "launch status", reg_rd_data, 32'h013C_A55A);
    wait_done("R7");
    check("R10", "write done word", reg_rd_data, 32'h043C_A55A);

    // R4: read access, written byte discarded
    lat = 5; m_rdata = 8'hC3;
    launch(16'h0042, 8'h77, 1'b1, 4'b1111, 16'h0042);
    check("R4", "read data byte ignored", {24'b0, reg_rd_data[23:16]}, 32'h3C);
    check("R7", "done cleared at launch", {31'b0, reg_rd_data[26]}, 32'd0);
    wait_done("R7");
    check("R4", "read data captured", {24'b0, reg_rd_data[23:16]}, 32'hC3);

    // R2: data byte only launches with stored addr and selector
    m_rdata = 8'h5A; lat = 2;
    launch(16'h0000, 8'h99, 1'b1, 4'b0100, 16'h0042);
    check("R2", "data-lane launch busy", {31'b0, reg_rd_data[24]}, 32'd1);
    wait_done("R7");
    check("R4", "second read", {24'b0, reg_rd_data[23:16]}, 32'h5A);

    // R8: error sticky, cleared by next launch
    m_err = 1'b1;
    launch(16'h0010, 8'h00, 1'b1, 4'b1111, 16'h0010);
    wait_done("R8");
    check("R8", "err set", {31'b0, reg_rd_data[27]}, 32'd1);
    reg_write(32'h0000_0777, 4'b0011);
    check("R8", "err held", {31'b0, reg_rd_data[27]}, 32'd1);
    check("R9", "addr updated", {16'b0, reg_rd_data[15:0]}, 32'h0777);
    m_err = 1'b0;
    launch(16'h0020, 8'hA1, 1'b0, 4'b1111, 16'h0020);
    check("R8", "err cleared at launch", {31'b0, reg_rd_data[27]}, 32'd0);
    wait_done("R8");
    check("R8", "no err", {31'b0, reg_rd_data[27]}, 32'd0);

    // R6: writes during busy are ignored
    lat = 15;
    launch(16'h0100, 8'h11, 1'b0, 4'b1111, 16'h0100);
    reg_write(32'hFFFF_FFFF, 4'b1111);
    check("R6", "fields frozen", reg_rd_data, 32'h0111_0100);
    reg_write(32'h0000_2222, 4'b0111);
    check("R6", "fields frozen 2", reg_rd_data, 32'h0111_0100);
    wait_done("R6");
    check("R6", "final word", reg_rd_data, 32'h0411_0100);

    repeat (20) @(negedge clk);
    check("R6", "no extra request", {31'b0, be_req}, 32'd0);
    check("R5", "scoreboard empty", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule